// File: doc/BRIEF.md
# Colour-Steered Parallel Element Memory

This block gives several soft-decoding processors simultaneous access to one shared store of trellis elements. The store is split over a bank of equal-sized RAMs. Which RAM holds an element is not fixed by address bits. Each element carries a small colour number, and the element lives in the RAM with that colour. Colours are assigned so that elements touched in the same cycle by different processors never share a RAM.

Every processor owns a private colour table. The table has one half for natural-order slots and one half for interleaved-order slots, and a configuration write port fills it. On each request the block does four things. It looks up the colour for the requested slot. It delays the address and write data to line up with that lookup. It steers the access to the RAM of that colour, at local address `index mod ceil(L/P)`. For a read, it routes the RAM's answer back to the requesting processor. Processor p is wired only to the lowest `min(NCOL, REACH_BASE+p)` RAMs. Any access whose colour falls outside that range is discarded.

Top module: `colour_bank_xbar`

## Requirements
- R1: While reset is held and in the first cycle after it, every `rd_valid` bit is 0.
- R2: A write by any processor, followed later by a read of the same element index with a table entry giving the same colour, returns the written word.
- R3: A read request presented in cycle t (with its colour reachable) raises `rd_valid` for that processor in cycle t+2 only, and not in cycle t+1.
- R4: Each processor's table has 2·2^AW entries addressed as `{phase, slot}` (phase 0 natural, phase 1 interleaved). A configuration write in cycle t is used by a request of that processor in cycle t+1.
- R5: An element is stored in RAM `colour` at local address `index mod ceil(L/P)`. So two indices that differ by a multiple of ceil(L/P) and map to the same colour address the same word, even from different processors.
- R6: Words at the same local address in RAMs of different colours are independent.
- R7: Processor p reaches only colours below `min(NCOL, REACH_BASE+p)`. A request with a higher colour neither writes any RAM nor raises `rd_valid`.
- R8: Up to P accesses per cycle, mixed reads and writes, all complete when their colours are distinct. No RAM is selected by two processors in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Colour table write strobe |
| cfg_proc | input | PW | Processor whose table is written |
| cfg_slot | input | AW+1 | Table entry `{phase, slot}` |
| cfg_colour | input | CW | Colour to store |
| req_valid | input | P | Request present, one bit per processor |
| req_we | input | P | 1 = write, 0 = read |
| req_phase | input | P | Table half: 0 natural, 1 interleaved |
| req_slot | input | P·AW | Table slot per processor |
| req_index | input | P·IW | Element index per processor |
| req_wdata | input | P·W | Write word per processor |
| rd_valid | output | P | Read data valid per processor |
| rd_data | output | P·W | Read word per processor |

## Verification
A wrong colour entry or a wrong steering decision shows up as a wrong word on `rd_data`. It appears two cycles after the read that exposes it, and may only show well after the write that went astray. A miscounted delay stage moves `rd_valid` off cycle t+2 at once. The bench writes every element from all processors at full rate, then reads everything back through both table halves in a permuted order. Aliased indices and unreachable colours are then probed directly.

// File: rtl/cbx_pkg.sv
package cbx_pkg;

    // Number of RAMs a given processor port is wired to.
    function automatic int reach_of(input int base, input int port, input int ncol);
        int r;
        r = base + port;
        if (r > ncol) r = ncol;
        if (r < 1) r = 1;
        return r;
    endfunction

endpackage

// File: rtl/cbx_colour_table.sv
module cbx_colour_table #(
    parameter int TAW = 5,
    parameter int CW  = 3
) (
    input  logic           clk,
    input  logic           wr_en,
    input  logic [TAW-1:0] wr_addr,
    input  logic [CW-1:0]  wr_colour,
    input  logic [TAW-1:0] rd_addr,
    output logic [CW-1:0]  rd_colour
);
    localparam int DEPTH = 2 ** TAW;

    logic [CW-1:0] entries [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) entries[wr_addr] <= wr_colour;
        rd_colour <= entries[rd_addr];
    end

endmodule

// File: rtl/cbx_ram.sv
module cbx_ram #(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int W     = 9
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) words[addr] <= wdata;
            else    rdata <= words[addr];
        end
    end

endmodule

// File: rtl/cbx_port_switch.sv
module cbx_port_switch #(
    parameter int L     = 64,
    parameter int N     = 16,
    parameter int AW    = 4,
    parameter int IW    = 6,
    parameter int NCOL  = 8,
    parameter int CW    = 3,
    parameter int W     = 9,
    parameter int REACH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tbl_we,
    input  logic [AW:0]     tbl_slot,
    input  logic [CW-1:0]   tbl_colour,
    input  logic            req_valid,
    input  logic            req_we,
    input  logic            req_phase,
    input  logic [AW-1:0]   req_slot,
    input  logic [IW-1:0]   req_index,
    input  logic [W-1:0]    req_wdata,
    output logic [NCOL-1:0] sel,
    output logic            s_we,
    output logic [AW-1:0]   s_addr,
    output logic [W-1:0]    s_wdata,
    output logic            ret_valid,
    output logic [CW-1:0]   ret_colour
);
    localparam logic [IW-1:0] N_V = IW'(N);

    logic [CW-1:0] colour;
    logic          s1_valid;

    cbx_colour_table #(.TAW(AW + 1), .CW(CW)) i_table (
        .clk       (clk),
        .wr_en     (tbl_we),
        .wr_addr   (tbl_slot),
        .wr_colour (tbl_colour),
        .rd_addr   ({req_phase, req_slot}),
        .rd_colour (colour)
    );

    // Delay stage matching the table lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s_we     <= 1'b0;
        end else begin
            s1_valid <= req_valid;
            s_we     <= req_valid && req_we;
        end
        s_addr  <= AW'(req_index % N_V);
        s_wdata <= req_wdata;
    end

    // Switch: only REACH output ports exist.
    for (genvar q = 0; q < NCOL; q++) begin : g_port
        if (q < REACH) begin : g_live
            assign sel[q] = s1_valid && (colour == CW'(q));
        end else begin : g_absent
            assign sel[q] = 1'b0;
        end
    end

    // Return-path delay stage matching the RAM read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_valid <= 1'b0;
        end else begin
            ret_valid <= (|sel) && !s_we;
        end
        ret_colour <= colour;
    end

    // R3
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> $past(req_valid && !req_we, 2));

    // R2
    wr_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s_we) |-> $past(req_valid && req_we));

endmodule

// File: rtl/colour_bank_xbar.sv
module colour_bank_xbar #(
    parameter int P          = 4,
    parameter int L          = 64,
    parameter int NCOL       = 8,
    parameter int W          = 9,
    parameter int REACH_BASE = 5,
    localparam int N         = (L + P - 1) / P,
    localparam int AW        = (N > 1) ? $clog2(N) : 1,
    localparam int IW        = (L > 1) ? $clog2(L) : 1,
    localparam int CW        = (NCOL > 1) ? $clog2(NCOL) : 1,
    localparam int PW        = (P > 1) ? $clog2(P) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [PW-1:0]   cfg_proc,
    input  logic [AW:0]     cfg_slot,
    input  logic [CW-1:0]   cfg_colour,
    input  logic [P-1:0]    req_valid,
    input  logic [P-1:0]    req_we,
    input  logic [P-1:0]    req_phase,
    input  logic [P*AW-1:0] req_slot,
    input  logic [P*IW-1:0] req_index,
    input  logic [P*W-1:0]  req_wdata,
    output logic [P-1:0]    rd_valid,
    output logic [P*W-1:0]  rd_data
);
    import cbx_pkg::*;

    localparam int NSLOT = 2 ** CW;

    logic [NCOL-1:0] sel        [P];
    logic            s_we       [P];
    logic [AW-1:0]   s_addr     [P];
    logic [W-1:0]    s_wdata    [P];
    logic [CW-1:0]   ret_colour [P];
    logic [P-1:0]    ret_valid;

    logic            ram_en   [NCOL];
    logic            ram_we   [NCOL];
    logic [AW-1:0]   ram_addr [NCOL];
    logic [W-1:0]    ram_wd   [NCOL];
    logic [P-1:0]    ram_who  [NCOL];
    logic [W-1:0]    ram_q    [NSLOT];

    for (genvar p = 0; p < P; p++) begin : g_proc
        cbx_port_switch #(
            .L(L), .N(N), .AW(AW), .IW(IW), .NCOL(NCOL), .CW(CW), .W(W),
            .REACH(reach_of(REACH_BASE, p, NCOL))
        ) i_switch (
            .clk        (clk),
            .rst_n      (rst_n),
            .tbl_we     (cfg_we && (cfg_proc == PW'(p))),
            .tbl_slot   (cfg_slot),
            .tbl_colour (cfg_colour),
            .req_valid  (req_valid[p]),
            .req_we     (req_we[p]),
            .req_phase  (req_phase[p]),
            .req_slot   (req_slot[p*AW +: AW]),
            .req_index  (req_index[p*IW +: IW]),
            .req_wdata  (req_wdata[p*W +: W]),
            .sel        (sel[p]),
            .s_we       (s_we[p]),
            .s_addr     (s_addr[p]),
            .s_wdata    (s_wdata[p]),
            .ret_valid  (ret_valid[p]),
            .ret_colour (ret_colour[p])
        );

        assign rd_valid[p]         = ret_valid[p];
        assign rd_data[p*W +: W]   = ram_q[ret_colour[p]];
    end

    // Per-RAM AND-OR gather of the one selecting port.
    always_comb begin
        for (int q = 0; q < NCOL; q++) begin
            ram_en[q]   = 1'b0;
            ram_we[q]   = 1'b0;
            ram_addr[q] = '0;
            ram_wd[q]   = '0;
            ram_who[q]  = '0;
            for (int p = 0; p < P; p++) begin
                ram_who[q][p] = sel[p][q];
                if (sel[p][q]) begin
                    ram_en[q]   = 1'b1;
                    ram_we[q]   = ram_we[q] | s_we[p];
                    ram_addr[q] = ram_addr[q] | s_addr[p];
                    ram_wd[q]   = ram_wd[q] | s_wdata[p];
                end
            end
        end
    end

    for (genvar q = 0; q < NSLOT; q++) begin : g_bank
        if (q < NCOL) begin : g_ram
            cbx_ram #(.DEPTH(N), .AW(AW), .W(W)) i_ram (
                .clk   (clk),
                .en    (ram_en[q]),
                .we    (ram_we[q]),
                .addr  (ram_addr[q]),
                .wdata (ram_wd[q]),
                .rdata (ram_q[q])
            );

            // R8
            ram_single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(ram_who[q]));
        end else begin : g_void
            assign ram_q[q] = '0;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (rd_valid == '0));

endmodule

// File: tb/test_colour_bank_xbar.sv
`timescale 1ns/1ps
module test_colour_bank_xbar;
    localparam int P = 4, L = 64, NCOL = 8, W = 9, RB = 5;
    localparam int N = 16, AW = 4, IW = 6, CW = 3, PW = 2;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            cfg_we;
    logic [PW-1:0]   cfg_proc;
    logic [AW:0]     cfg_slot;
    logic [CW-1:0]   cfg_colour;
    logic [P-1:0]    req_valid, req_we, req_phase;
    logic [P*AW-1:0] req_slot;
    logic [P*IW-1:0] req_index;
    logic [P*W-1:0]  req_wdata;
    logic [P-1:0]    rd_valid;
    logic [P*W-1:0]  rd_data;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    colour_bank_xbar #(.P(P), .L(L), .NCOL(NCOL), .W(W), .REACH_BASE(RB)) i_colour_bank_xbar (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_proc(cfg_proc),
        .cfg_slot(cfg_slot), .cfg_colour(cfg_colour), .req_valid(req_valid),
        .req_we(req_we), .req_phase(req_phase), .req_slot(req_slot),
        .req_index(req_index), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    function automatic logic [W-1:0] word_of(input int idx);
        return W'((idx * 37 + 11) % 512);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_all();
        req_valid = '0; req_we = '0; req_phase = '0;
        req_slot = '0; req_index = '0; req_wdata = '0;
    endtask

    task automatic set_req(input int p, input bit wr, input bit ph, input int slot,
                           input int idx, input int data);
        req_valid[p]         = 1'b1;
        req_we[p]            = wr;
        req_phase[p]         = ph;
        req_slot[p*AW +: AW] = AW'(slot);
        req_index[p*IW +: IW]= IW'(idx);
        req_wdata[p*W +: W]  = W'(data);
    endtask

    task automatic cfg_load(input int p, input int tslot, input int col);
        cfg_we = 1'b1; cfg_proc = PW'(p); cfg_slot = 5'(tslot); cfg_colour = CW'(col);
        tick();
        cfg_we = 1'b0;
    endtask

    // Issue already-set requests, clear, check that no read arrives at t+1.
    task automatic issue_reads(input string tag);
        tick();
        idle_all();
        chk({tag, " R3 no data at t+1"}, int'(rd_valid), 0);
        tick();
    endtask

    initial begin
        rst_n = 1'b0;
        cfg_we = 1'b0; cfg_proc = '0; cfg_slot = '0; cfg_colour = '0;
        idle_all();
        repeat (3) tick();
        chk("R1 rd_valid in reset", int'(rd_valid), 0);
        rst_n = 1'b1;
        tick();
        chk("R1 rd_valid after reset", int'(rd_valid), 0);

        // R4: tables: natural slot m -> colour (p+m)%4, interleaved slot m -> ((p+1)+m)%4
        for (int p = 0; p < P; p++)
            for (int m = 0; m < N; m++) begin
                cfg_load(p, m, (p + m) % 4);
                cfg_load(p, 16 + m, ((p + 1) % 4 + m) % 4);
            end

        // R8: all four processors write every cycle, distinct colours
        for (int m = 0; m < N; m++) begin
            idle_all();
            for (int p = 0; p < P; p++) set_req(p, 1, 0, m, p * N + m, word_of(p * N + m));
            tick();
        end
        idle_all();
        tick();

        // R2/R5: interleaved-half reads of the neighbour's elements
        for (int m = 0; m < N; m++) begin
            for (int p = 0; p < P; p++) set_req(p, 0, 1, m, ((p + 1) % 4) * N + m, 0);
            issue_reads("R2 permuted");
            chk("R3 rd_valid at t+2", int'(rd_valid), 15);
            for (int p = 0; p < P; p++)
                chk("R2 permuted read", int'(rd_data[p*W +: W]), int'(word_of(((p + 1) % 4) * N + m)));
        end

        // R2: natural-half reads of own elements
        for (int m = 0; m < N; m++) begin
            for (int p = 0; p < P; p++) set_req(p, 0, 0, m, p * N + m, 0);
            issue_reads("R2 own");
            for (int p = 0; p < P; p++)
                chk("R2 own read", int'(rd_data[p*W +: W]), int'(word_of(p * N + m)));
        end

        // R5: proc0, colour 1, index 0 aliases element 16 (RAM1 addr0)
        cfg_load(0, 31, 1);
        set_req(0, 0, 1, 15, 0, 0);
        issue_reads("R5");
        chk("R5 alias valid", int'(rd_valid[0]), 1);
        chk("R5 alias word", int'(rd_data[0 +: W]), int'(word_of(16)));

        // R7: colour 6 is out of reach for proc0 (reach 5), in reach for proc3
        cfg_load(0, 30, 6);
        cfg_load(3, 30, 6);
        set_req(3, 1, 1, 14, 3, 9'h1AA);
        tick();
        idle_all();
        set_req(0, 1, 1, 14, 3, 9'h055);
        tick();
        idle_all();
        set_req(0, 0, 1, 14, 3, 0);
        issue_reads("R7 far");
        chk("R7 no rd_valid beyond reach", int'(rd_valid[0]), 0);
        set_req(3, 0, 1, 14, 3, 0);
        issue_reads("R7 near");
        chk("R7 valid", int'(rd_valid[3]), 1);
        chk("R7 discarded write", int'(rd_data[3*W +: W]), 9'h1AA);

        // R6: colours 6 and 7 at the same local address stay apart
        cfg_load(2, 29, 6);
        cfg_load(3, 29, 7);
        set_req(2, 1, 1, 13, 5, 9'h0C3);
        set_req(3, 1, 1, 13, 21, 9'h13C);
        tick();
        idle_all();
        set_req(2, 0, 1, 13, 5, 0);
        set_req(3, 0, 1, 13, 21, 0);
        issue_reads("R6");
        chk("R6 colour6 word", int'(rd_data[2*W +: W]), 9'h0C3);
        chk("R6 colour7 word", int'(rd_data[3*W +: W]), 9'h13C);

        // R4: config write in t used by request in t+1
        cfg_load(1, 28, 2);
        set_req(1, 0, 1, 12, 0, 0);
        issue_reads("R4 a");
        chk("R4 new colour 2", int'(rd_data[1*W +: W]), int'(word_of(32)));
        cfg_load(1, 28, 3);
        set_req(1, 0, 1, 12, 0, 0);
        issue_reads("R4 b");
        chk("R4 new colour 3", int'(rd_data[1*W +: W]), int'(word_of(48)));

        // R8: mixed read and write in one cycle
        set_req(0, 1, 0, 1, 1, 9'h0AB);
        set_req(1, 0, 0, 1, 17, 0);
        issue_reads("R8 mix");
        chk("R8 mixed read", int'(rd_data[1*W +: W]), int'(word_of(17)));
        set_req(0, 0, 0, 1, 1, 0);
        issue_reads("R8 mix back");
        chk("R8 mixed write", int'(rd_data[0 +: W]), 9'h0AB);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule